// File: doc/BRIEF.md
# Leading Zero Counter with First-One Mask

This block counts how many zero bits sit above the highest set bit of an unsigned word. It leaves the data unshifted. The work happens in two stages. The first stage builds a mask that is one-hot at the most significant '1' of the input. The second stage turns that mask into a binary count using only OR gates, so no carry has to ripple through the encoder.

Alongside the count, the block raises a flag when the input is all zeros. In that case the count equals the full input width, which is why the count output is one bit wider than log2 of the width. The width is a parameter and must be a power of two from 4 to 32.

A second parameter chooses between two output styles. The results can pass straight through with the input strobe, or they can be captured in an output register and appear one clock later with their own valid strobe. Downstream logic uses the count for tasks such as exponent estimation or scaling decisions.

Top module: `lzc_first_one_counter`

## Requirements
- R1: `lz_count` equals the number of consecutive zero bits in `din` counted from bit WIDTH-1 downward until the first '1'.
- R2: For WIDTH=4, the inputs 1xxx, 01xx, 001x, 0001 and 0000 give counts 0, 1, 2, 3 and 4.
- R3: An all-zero `din` gives `lz_count` equal to WIDTH. The count is $clog2(WIDTH)+1 bits wide.
- R4: `all_zero` is 1 exactly when `din` is zero. It is also the most significant bit of `lz_count`.
- R5: The internal first-one mask has at most one bit set. It is empty only for a zero input. When a bit is set, it is the bit at position WIDTH-1-`lz_count`.
- R6: With OUT_REG=1, each word presented with `din_valid`=1 produces its `lz_count` and `all_zero` one clock later, and `out_valid` is 1 in that cycle. Back-to-back words give back-to-back results in order.
- R7: With OUT_REG=1, a cycle with `din_valid`=0 leaves `lz_count` and `all_zero` unchanged, whatever `din` holds, and gives `out_valid`=0 after the next edge.
- R8: With OUT_REG=1, `rst_n` low clears `out_valid` at once and holds it at 0 while reset is asserted.
- R9: With OUT_REG=0, `lz_count` and `all_zero` follow `din` in the same cycle, and `out_valid` equals `din_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| din_valid | input | 1 | Strobe marking a word on `din` |
| din | input | WIDTH | Unsigned input word |
| out_valid | output | 1 | Result strobe |
| lz_count | output | $clog2(WIDTH)+1 | Leading zero count, 0 to WIDTH |
| all_zero | output | 1 | High when the input word is zero |

## Verification
In registered mode, the result register can load a new word in the same cycle that it presents the previous result. The bench provokes this by streaming words back to back, including all-zero words and words with a single set bit, so that every capture overlaps a presentation. It judges the stream by matching each result, in order, against an expected entry queued when the word was driven. A separate check on a narrow, unregistered instance covers every possible input word. That instance's strobe is toggled to confirm that it passes through in the same cycle.

// File: rtl/lzc_pkg.sv
package lzc_pkg;
  // Width of the count port: enough to encode 0..width inclusive.
  function automatic int unsigned lzc_cnt_bits(input int unsigned width);
    return $clog2(width) + 1;
  endfunction
endpackage

// File: rtl/lzc_first_one_mask.sv
module lzc_first_one_mask #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] mask,
  output logic             nonzero
);
  // seen_above[i] is the OR of data[WIDTH-1:i]; seen_above[WIDTH] is zero.
  logic [WIDTH:0] seen_above;

  assign seen_above[WIDTH] = 1'b0;

  genvar gi;
  generate
    for (gi = WIDTH - 1; gi >= 0; gi--) begin : g_bit
      assign seen_above[gi] = seen_above[gi+1] | data[gi];
      assign mask[gi]       = data[gi] & ~seen_above[gi+1];
    end
  endgenerate

  assign nonzero = seen_above[0];

  always_comb begin
    if (!$isunknown(data)) begin
      AST_MASK_ONEHOT0: assert ($onehot0(mask)); // R5
      AST_MASK_EMPTY_ON_ZERO: assert ((mask == '0) == (data == '0)); // R5
    end
  end
endmodule

// File: rtl/lzc_onehot_encoder.sv
module lzc_onehot_encoder #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned CNT_W = lzc_pkg::lzc_cnt_bits(WIDTH)
) (
  input  logic [WIDTH-1:0] mask,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned LOG_W = CNT_W - 1;

  // Mask bit i stands for a count of WIDTH-1-i. Count bit b is the OR of
  // all mask positions whose count has bit b set, so no carry ripples.
  genvar gb, gi;
  generate
    for (gb = 0; gb < LOG_W; gb++) begin : g_cbit
      logic [WIDTH-1:0] pick;
      for (gi = 0; gi < WIDTH; gi++) begin : g_pos
        if ((((WIDTH - 1 - gi) >> gb) & 1) != 0) begin : g_on
          assign pick[gi] = mask[gi];
        end else begin : g_off
          assign pick[gi] = 1'b0;
        end
      end
      assign count[gb] = |pick;
    end
  endgenerate

  // Empty mask: the low bits are already zero, so the top bit alone gives WIDTH.
  assign count[LOG_W] = ~|mask;

  always_comb begin
    if (!$isunknown(mask) && $onehot0(mask)) begin
      AST_ENC_RANGE: assert (count <= CNT_W'(WIDTH)); // R3
    end
  end
endmodule

// File: rtl/lzc_first_one_counter.sv
module lzc_first_one_counter #(
  parameter int unsigned WIDTH   = 16,
  parameter bit          OUT_REG = 1'b1,
  parameter int unsigned CNT_W   = lzc_pkg::lzc_cnt_bits(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din_valid,
  input  logic [WIDTH-1:0] din,
  output logic             out_valid,
  output logic [CNT_W-1:0] lz_count,
  output logic             all_zero
);
  localparam int unsigned LOG_W = CNT_W - 1;

  logic [WIDTH-1:0] first_mask;
  logic             din_nonzero;
  logic [CNT_W-1:0] cnt_c;
  logic             zero_c;

  lzc_first_one_mask #(.WIDTH(WIDTH)) u_mask (
    .data    (din),
    .mask    (first_mask),
    .nonzero (din_nonzero)
  );

  lzc_onehot_encoder #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_enc (
    .mask  (first_mask),
    .count (cnt_c)
  );

  assign zero_c = cnt_c[LOG_W];

  always_comb begin
    if (!$isunknown(din)) begin
      AST_FLAG_MATCHES_DATA: assert (zero_c == !din_nonzero); // R4
      if (!zero_c) begin
        AST_MASK_AT_COUNT: assert (first_mask[WIDTH-1-int'(cnt_c[LOG_W-1:0])]); // R5
      end
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      logic             valid_q, valid_d;
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             zero_q, zero_d;
      logic             load_en;

      assign load_en = din_valid;

      always_comb begin
        valid_d = din_valid;
        cnt_d   = cnt_q;
        zero_d  = zero_q;
        if (load_en) begin
          cnt_d  = cnt_c;
          zero_d = zero_c;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_d;
      end

      always_ff @(posedge clk) begin
        cnt_q  <= cnt_d;
        zero_q <= zero_d;
      end

      assign out_valid = valid_q;
      assign lz_count  = cnt_q;
      assign all_zero  = zero_q;

      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        din_valid |=> out_valid); // R6
      AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !din_valid |=> !out_valid); // R7
      AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !din_valid) |=> ($stable(lz_count) && $stable(all_zero))); // R7
      AST_ZERO_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (all_zero == (lz_count == CNT_W'(WIDTH)))); // R3
    end else begin : g_comb
      assign out_valid = din_valid;
      assign lz_count  = cnt_c;
      assign all_zero  = zero_c;
    end
  endgenerate
endmodule

// File: tb/tb_lzc_first_one_counter.sv
module tb_lzc_first_one_counter;
  localparam int W  = 16;
  localparam int CW = 5;

  logic          clk;
  logic          rst_n;
  logic          din_valid;
  logic [W-1:0]  din;
  logic          out_valid;
  logic [CW-1:0] lz_count;
  logic          all_zero;

  logic          v4;
  logic [3:0]    d4;
  logic          ov4;
  logic [2:0]    c4;
  logic          z4;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [CW:0] exp_q[$];

  lzc_first_one_counter #(.WIDTH(W), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .din_valid(din_valid), .din(din),
    .out_valid(out_valid), .lz_count(lz_count), .all_zero(all_zero));

  lzc_first_one_counter #(.WIDTH(4), .OUT_REG(1'b0)) dut4 (
    .clk(clk), .rst_n(rst_n), .din_valid(v4), .din(d4),
    .out_valid(ov4), .lz_count(c4), .all_zero(z4));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int ref_lz(input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) if (v[i]) return w - 1 - i;
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] d);
    int e;
    @(negedge clk);
    din_valid = 1'b1;
    din       = d;
    e = ref_lz(32'(d), W);
    exp_q.push_back({(d == '0), CW'(e)});
  endtask

  task automatic idle(input logic [W-1:0] d);
    @(negedge clk);
    din_valid = 1'b0;
    din       = d;
  endtask

  // Monitor: pops one expected entry per result strobe (R1, R3, R4, R6).
  always @(posedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 spurious out_valid", 1, 0);
      end else begin
        logic [CW:0] e;
        e = exp_q.pop_front();
        check(lz_count == e[CW-1:0], "R1 count", int'(lz_count), int'(e[CW-1:0]));
        check(all_zero == e[CW], "R4 zero flag", int'(all_zero), int'(e[CW]));
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; din_valid = 1'b0; din = '0; v4 = 1'b0; d4 = '0;
    repeat (3) @(posedge clk);
    #1 check(out_valid == 1'b0, "R8 valid in reset", int'(out_valid), 0);

    // R2, R9: exhaustive narrow unregistered instance
    for (int v = 0; v < 16; v++) begin
      v4 = 1'b1; d4 = 4'(v);
      #1;
      check(c4 == 3'(ref_lz(32'(v), 4)), "R2 4-bit count", int'(c4), ref_lz(32'(v), 4));
      check(z4 == (v == 0), "R9 4-bit flag", int'(z4), int'(v == 0));
      check(ov4 == 1'b1, "R9 valid pass", int'(ov4), 1);
    end
    v4 = 1'b0; d4 = 4'b0001; #1;
    check(ov4 == 1'b0, "R9 valid low", int'(ov4), 0);
    check(c4 == 3'd3, "R2 0001 count", int'(c4), 3);

    @(negedge clk); rst_n = 1'b1;

    // R3: all-zero, then each single-bit word, back to back (R6)
    drive('0);
    for (int i = 0; i < W; i++) drive(W'(1) << i);
    drive('0);
    drive({W{1'b1}});
    // random words with varied leading zeros
    for (int n = 0; n < 300; n++) begin
      logic [W-1:0] r;
      r = W'($urandom) >> $urandom_range(0, W);
      drive(r);
      if (n % 37 == 0) idle(W'($urandom));
    end

    // R7: idle cycle with different data leaves result held
    drive(16'h0100);
    idle(16'hFFFF);
    @(posedge clk); #1;
    check(lz_count == CW'(7), "R7 hold count", int'(lz_count), 7);
    check(all_zero == 1'b0, "R7 hold flag", int'(all_zero), 0);
    check(out_valid == 1'b0, "R7 valid low", int'(out_valid), 0);

    // R8: reset mid-stream clears valid
    @(negedge clk);
    din_valid = 1'b1; din = 16'h0001; rst_n = 1'b0;
    #1 check(out_valid == 1'b0, "R8 async clear", int'(out_valid), 0);
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R8 held in reset", int'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1; din_valid = 1'b0;
    drive(16'h0003);
    idle('0);
    @(posedge clk); #1;
    check(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule